// File: doc/BRIEF.md
# Prescaled Register-Mapped PWM Controller

This block produces one or two pulse-width-modulated outputs from a single input clock. Each channel divides the clock by a programmable prescaler to form a counting tick, then counts ticks through a programmable period. The output is high for a programmable number of ticks at the start of each period. A flag in the duty register forces the output high for the whole period.

Software programs three registers per channel over a byte-addressed word register bus with a write strobe and a combinational read path. A per-channel enable input starts and stops the waveform. The stop behaviour is chosen per channel by a control bit. With the bit set, the output drops at the next clock. With the bit clear, the current period runs to its end.

New duty, period and prescale values are captured into a working copy only at the start of a period. A waveform in progress is therefore never torn by a register write.

Top module: `pwm_ctrl`

## Requirements
- R1: Registers are addressed by `addr_i[4]` (channel) and `addr_i[3:2]` (0: control, 1: duty, 2: period, 3: reserved). Control holds the prescale in bits [5:0] and the abrupt-stop bit in bit 6. Duty holds the count in bits [9:0] and the full-duty flag in bit 10. Period holds the period value in bits [9:0]. A read returns the last written field values, and every other bit reads as zero, as does the reserved slot.
- R2: After reset all registers read zero and every output is low.
- R3: While a channel runs with prescale P, period value V and duty count D (flag clear, D ≤ V+1), each period lasts (P+1)*(V+1) clocks, and the output is high for the first (P+1)*D of them.
- R4: With the full-duty flag set, the output is high for the whole period whatever the duty count.
- R5: A duty count of 0 (flag clear) gives a constantly low output. A duty count above V+1 gives a constantly high output.
- R6: Writes to the duty, period or prescale fields while a channel runs change the waveform only from the next period boundary on.
- R7: With the abrupt-stop bit set, deasserting the enable stops the channel at the next clock edge, and the output is low from then on.
- R8: With the abrupt-stop bit clear, deasserting the enable lets the current period finish, and the output is low from the following period boundary on.
- R9: Channels are independent: one channel's registers and enable never affect the other channel's output.
- R10: An enable seen high at a clock edge by an idle channel starts a period at that edge. The first output cycle follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| en_i | input | NCH | Per-channel enable |
| pwm_o | output | NCH | Per-channel waveform output, active high |

## Verification
The bench compares every cycle of whole periods against a waveform computed from the prescale, period and duty values. A wrong prescale or period count shows up as a shifted edge. A duty count of zero, a count above the period, and the full-duty flag probe the saturation cases, where an off-by-one comparison gives a one-tick glitch. A mid-period duty write must leave the running period intact, so a design that loads its working copy immediately shows a wrong pulse width in the first period. Both stop modes are exercised. An abrupt stop that waits for the boundary, or a graceful stop that cuts the period short, both show up at the exact cycle the output should fall.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PRE_W  = 6;
  localparam int CNT_W  = 10;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_DUTY = 2'd1;
  localparam logic [1:0] REG_PER  = 2'd2;

  localparam int SD_BIT = 6;
  localparam int FD_BIT = 10;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] pv;
    logic [CNT_W-1:0] dc;
    logic             fd;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output pwm_cfg_t          cfg_o [NCH],
  output logic [NCH-1:0]    sd_o
);
  logic       ch_sel;
  logic [1:0] reg_sel;
  logic [DATA_W-1:0] rd_w [NCH];
  logic unused_bits;

  assign ch_sel  = addr_i[4];
  assign reg_sel = addr_i[3:2];
  assign unused_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:FD_BIT+1]};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_cfg_t cfg_q;
    logic     sd_q;
    logic     sel;

    assign sel = we_i && (ch_sel == c[0]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q <= '0;
        sd_q  <= 1'b0;
      end else if (sel) begin
        case (reg_sel)
          REG_CTRL: begin
            cfg_q.pre <= wdata_i[PRE_W-1:0];
            sd_q      <= wdata_i[SD_BIT];
          end
          REG_DUTY: begin
            cfg_q.dc <= wdata_i[CNT_W-1:0];
            cfg_q.fd <= wdata_i[FD_BIT];
          end
          REG_PER: cfg_q.pv <= wdata_i[CNT_W-1:0];
          default: ;
        endcase
      end
    end

    always_comb begin
      rd_w[c] = '0;
      case (reg_sel)
        REG_CTRL: begin
          rd_w[c][PRE_W-1:0] = cfg_q.pre;
          rd_w[c][SD_BIT]    = sd_q;
        end
        REG_DUTY: begin
          rd_w[c][CNT_W-1:0] = cfg_q.dc;
          rd_w[c][FD_BIT]    = cfg_q.fd;
        end
        REG_PER: rd_w[c][CNT_W-1:0] = cfg_q.pv;
        default: ;
      endcase
    end

    assign cfg_o[c] = cfg_q;
    assign sd_o[c]  = sd_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (ch_sel == c[0]) rdata_o = rd_w[c];
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     sd_i,
  input  pwm_cfg_t cfg_i,
  output logic     pwm_o,
  output logic     run_o,
  output logic     pend_o,
  output pwm_cfg_t act_o
);
  logic             run_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] per_q;
  pwm_cfg_t         act_q;
  logic             tick, pend;

  assign tick = run_q && (pre_q == act_q.pre);
  assign pend = tick && (per_q == act_q.pv);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pre_q <= '0;
      per_q <= '0;
      act_q <= '0;
    end else if (!run_q) begin
      if (en_i) begin
        run_q <= 1'b1;
        act_q <= cfg_i;
        pre_q <= '0;
        per_q <= '0;
      end
    end else if (!en_i && sd_i) begin
      // abrupt stop: drop at this edge
      run_q <= 1'b0;
      pre_q <= '0;
      per_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (pend) begin
        per_q <= '0;
        act_q <= cfg_i;
        if (!en_i) run_q <= 1'b0;
      end else if (tick) begin
        per_q <= per_q + 1'b1;
      end
    end
  end

  // dc above pv+1 saturates naturally since per_q never exceeds pv
  assign pwm_o  = run_q && (act_q.fd || (per_q < act_q.dc));
  assign run_o  = run_q;
  assign pend_o = pend;
  assign act_o  = act_q;
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NCH-1:0]    en_i,
  output logic [NCH-1:0]    pwm_o
);
  pwm_cfg_t       cfg_w [NCH];
  pwm_cfg_t       act_w [NCH];
  logic [NCH-1:0] sd_w, run_w, pend_w;

  pwm_regfile #(.NCH(NCH)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cfg_o(cfg_w), .sd_o(sd_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm_chan u_chan (
      .clk_i, .rst_ni,
      .en_i  (en_i[c]),
      .sd_i  (sd_w[c]),
      .cfg_i (cfg_w[c]),
      .pwm_o (pwm_o[c]),
      .run_o (run_w[c]),
      .pend_o(pend_w[c]),
      .act_o (act_w[c])
    );
  end
endmodule

// File: rtl/pwm_ctrl_chk.sv
module pwm_ctrl_chk
  import pwm_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] en_i,
  input logic [NCH-1:0] sd_w,
  input logic [NCH-1:0] run_w,
  input logic [NCH-1:0] pend_w,
  input logic [NCH-1:0] pwm_o,
  input pwm_cfg_t       act_w [NCH]
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_w[c] && en_i[c]) |=> run_w[c]);
    p_abrupt_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w[c] && !en_i[c] && sd_w[c]) |=> !pwm_o[c]);
    p_graceful_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w[c] && !en_i[c] && !sd_w[c] && !pend_w[c]) |=> run_w[c]);
    p_graceful_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w[c] && !en_i[c] && !sd_w[c] && pend_w[c]) |=> !run_w[c]);
    p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w[c] && !pend_w[c] && (en_i[c] || !sd_w[c])) |=> $stable(act_w[c]));
    p_full_duty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w[c] && act_w[c].fd) |-> pwm_o[c]);
  end
endmodule

bind pwm_ctrl pwm_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk_i, .rst_ni, .en_i, .sd_w, .run_w, .pend_w, .pwm_o, .act_w
);

// File: tb/pwm_ctrl_tb_top.sv
module pwm_ctrl_tb_top;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] en = '0;
  logic [NCH-1:0] pwm;

  int n_cmp = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_ctrl #(.NCH(NCH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .en_i(en), .pwm_o(pwm)
  );

  task automatic chk(bit ok, string tag, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic bit exp_pwm(int pre, int pv, int dc, bit fd, int i);
    int k = (pre + 1) * (pv + 1);
    int h = fd ? k : (pre + 1) * ((dc > pv + 1) ? pv + 1 : dc);
    return (i % k) < h;
  endfunction

  task automatic bus_wr(int a, int d);
    @(negedge clk);
    we = 1'b1; addr = 5'(a); wdata = 32'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(int a, int expv, string tag);
    @(negedge clk);
    addr = 5'(a);
    #1;
    chk(rdata == 32'(expv), tag, int'(rdata), expv);
  endtask

  // programs a channel, runs nper periods checking every cycle, then graceful stop
  task automatic run_chk(int ch, int pre, int pv, int dc, bit fd, int nper, string tag);
    int k = (pre + 1) * (pv + 1);
    int bad = 0;
    int oth = 1 - ch;
    bus_wr(ch * 16 + 0, pre);
    bus_wr(ch * 16 + 4, (int'(fd) << 10) | dc);
    bus_wr(ch * 16 + 8, pv);
    en[ch] = 1'b1;
    for (int i = 0; i < nper * k; i++) begin
      @(negedge clk);
      if (pwm[ch] !== exp_pwm(pre, pv, dc, fd, i) || pwm[oth] !== 1'b0) bad++;
    end
    chk(bad == 0, tag, bad, 0);
    en[ch] = 1'b0;
    @(negedge clk);
    chk(pwm[ch] == 1'b0, "R8 low after period end", int'(pwm[ch]), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #23 rst_n = 1'b1;

    // R2 reset state
    rd_chk(5'h00, 0, "R2 ch0 ctrl reset");
    rd_chk(5'h04, 0, "R2 ch0 duty reset");
    rd_chk(5'h18, 0, "R2 ch1 period reset");
    chk(pwm == '0, "R2 outputs low", int'(pwm), 0);

    // R1 field masking and map
    bus_wr(5'h10, 32'hFFFF_FFFF);
    bus_wr(5'h14, 32'hFFFF_FFFF);
    bus_wr(5'h18, 32'hFFFF_FFFF);
    bus_wr(5'h1C, 32'hFFFF_FFFF);
    rd_chk(5'h10, 32'h7F,  "R1 ctrl mask");
    rd_chk(5'h14, 32'h7FF, "R1 duty mask");
    rd_chk(5'h18, 32'h3FF, "R1 period mask");
    rd_chk(5'h1C, 0,       "R1 reserved slot");
    rd_chk(5'h04, 0,       "R9 ch0 untouched by ch1 writes");
    bus_wr(5'h10, 0); bus_wr(5'h14, 0); bus_wr(5'h18, 0);

    // R3 / R10 directed
    run_chk(0, 1, 4, 2, 1'b0, 2, "R3 R10 pre1 pv4 dc2");
    run_chk(1, 0, 9, 3, 1'b0, 2, "R3 R9 ch1 pre0 pv9 dc3");
    // R4 full duty
    run_chk(0, 2, 3, 1, 1'b1, 2, "R4 full-duty flag");
    // R5 edges
    run_chk(0, 0, 5, 0, 1'b0, 2, "R5 dc zero low");
    run_chk(1, 1, 5, 900, 1'b0, 2, "R5 dc above period");
    run_chk(0, 0, 5, 6, 1'b0, 2, "R5 dc equal pv+1");
    // large corners
    run_chk(0, 63, 3, 2, 1'b0, 1, "R3 max prescale");
    run_chk(1, 0, 1023, 1000, 1'b0, 1, "R3 max period");

    // R6 mid-period duty update
    begin
      int bad = 0;
      bus_wr(5'h00, 1); bus_wr(5'h04, 2); bus_wr(5'h08, 7);
      en[0] = 1'b1;
      for (int i = 0; i < 32; i++) begin
        @(negedge clk);
        if (pwm[0] !== ((i < 16) ? exp_pwm(1, 7, 2, 1'b0, i) : exp_pwm(1, 7, 6, 1'b0, i - 16))) bad++;
        if (i == 3) begin we = 1'b1; addr = 5'h04; wdata = 32'd6; end
        if (i == 4) we = 1'b0;
      end
      chk(bad == 0, "R6 update at boundary", bad, 0);
      en[0] = 1'b0;
      @(negedge clk);
    end

    // R7 abrupt stop
    begin
      int bad = 0;
      bus_wr(5'h10, 32'h42); bus_wr(5'h14, 32'h400); bus_wr(5'h18, 9);
      rd_chk(5'h10, 32'h42, "R1 R7 ctrl readback with stop bit");
      en[1] = 1'b1;
      for (int i = 0; i < 7; i++) begin
        @(negedge clk);
        if (pwm[1] !== 1'b1) bad++;
      end
      chk(bad == 0, "R7 high before stop", bad, 0);
      en[1] = 1'b0;
      @(negedge clk);
      chk(pwm[1] == 1'b0, "R7 low next clock", int'(pwm[1]), 0);
      bad = 0;
      repeat (40) begin @(negedge clk); if (pwm[1] !== 1'b0) bad++; end
      chk(bad == 0, "R7 stays low", bad, 0);
    end

    // R8 graceful stop mid-period
    begin
      int bad = 0;
      bus_wr(5'h00, 1); bus_wr(5'h04, 32'h400); bus_wr(5'h08, 4);
      en[0] = 1'b1;
      for (int i = 0; i < 4; i++) @(negedge clk);
      en[0] = 1'b0;
      for (int i = 4; i < 10; i++) begin
        @(negedge clk);
        if (pwm[0] !== 1'b1) bad++;
      end
      chk(bad == 0, "R8 period completes", bad, 0);
      @(negedge clk);
      chk(pwm[0] == 1'b0, "R8 low at boundary", int'(pwm[0]), 0);
    end

    // constrained random
    for (int t = 0; t < 24; t++) begin
      int ch  = int'($urandom_range(1, 0));
      int pre = int'($urandom_range(3, 0));
      int pv  = int'($urandom_range(12, 0));
      int dc  = int'($urandom_range(15, 0));
      bit fd  = ($urandom_range(7, 0) == 0);
      run_chk(ch, pre, pv, dc, fd, 2, "R3 R4 R5 random config");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule